// File: doc/BRIEF.md
# Registered ROM with Programmable Initialize Word

This block is a read-only memory of 2048 bytes. Its output is held in an edge-triggered register. On each rising clock edge the register takes the byte stored at the presented address. A level-sensitive, active-low initialize input loads a separate programmable byte into that register at once, without waiting for a clock. That byte acts as a 2049th word. Set to all ones it presets the outputs, and set to all zeros it clears them.

The outputs are gated by an active-low enable, and a configuration bit picks how that enable acts. In registered mode the enable is sampled on the clock edge, and the initialize input also forces it on. In direct mode it gates the outputs combinationally. There is no bidirectional pad. A valid flag tells when the outputs are driven, and the data lines read as zero while they are not. Array bytes are loaded through a synchronous write port. A second strobe loads the initialize word and the enable mode. Until something is written, every location reads as 0xFF, which is the erased state.

Top module: `regrom_top`

## Requirements
- R1: After reset every array location and the initialize word read as 0xFF until written.
- R2: The data register takes the array byte at the address present at a rising clock edge, and the outputs change only after that edge.
- R3: A rising edge with `pgm_we` high stores `pgm_data` at `pgm_addr`, and later reads of that address return it.
- R4: Driving `init_n` low loads the initialize word into the data register at once, with no clock edge needed.
- R5: While `init_n` stays low across clock edges the register keeps the initialize word and ignores the array.
- R6: The initialize word takes any value through `cfg_we`. 0xFF acts as a preset and 0x00 as a clear of the outputs.
- R7: In direct mode (`cfg_oe_sync` stored as 0) `q_valid` equals the inverse of `oe_n` combinationally.
- R8: In registered mode (`cfg_oe_sync` stored as 1) `q_valid` follows the value of `oe_n` sampled at the previous rising edge. A low sample enables the outputs.
- R9: `init_n` low forces the registered enable to the enabled state at once.
- R10: While `q_valid` is low, `q` reads as 0x00.
- R11: A rising edge with `cfg_we` high stores the initialize word and the enable mode together.
- R12: Reset sets the data register to 0xFF, the registered enable to disabled and the mode to direct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously inside |
| addr | input | 11 | Read address |
| init_n | input | 1 | Active-low level-sensitive initialize |
| oe_n | input | 1 | Active-low output enable |
| pgm_we | input | 1 | Array write strobe |
| pgm_addr | input | 11 | Array write address |
| pgm_data | input | 8 | Array write data |
| cfg_we | input | 1 | Initialize word and mode write strobe |
| cfg_init_word | input | 8 | Initialize word value |
| cfg_oe_sync | input | 1 | Enable mode: 1 registered, 0 direct |
| q | output | 8 | Data output, zero when not valid |
| q_valid | output | 1 | High while the outputs are driven |

## Verification
The bench builds the block with its default parameters: an 11-bit address and 8-bit data. That covers the full 2048-entry array, so random writes and reads reach both ends of the address range. Untouched locations also stay in play and must read as erased. The 8-bit width lets the initialize word take the all-ones, all-zeros and mixed patterns. The bench switches between direct and registered enable in one run, so the two modes meet the initialize input in both orders.

// File: rtl/regrom_pkg.sv
package regrom_pkg;
  typedef enum logic {
    OE_DIRECT = 1'b0,
    OE_REGD   = 1'b1
  } oe_mode_e;
endpackage

// File: rtl/regrom_rst_sync.sv
module regrom_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/regrom_array.sv
module regrom_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [DEPTH-1:0]  written_q;
  logic [DEPTH-1:0]  written_d;

  always_comb begin
    written_d = written_q;
    if (wr_en) written_d[wr_addr] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) written_q <= '0;
    else        written_q <= written_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  assign rd_data = written_q[rd_addr] ? store[rd_addr] : {DATA_W{1'b1}};

  // R3: a write lands in the store and marks the location
  p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(rst_n)) |->
      (store[$past(wr_addr)] == $past(wr_data) && written_q[$past(wr_addr)]));
endmodule

// File: rtl/regrom_cfg.sv
module regrom_cfg
  import regrom_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_word,
  input  logic              cfg_sync,
  output logic [DATA_W-1:0] init_word,
  output oe_mode_e          oe_mode
);
  logic [DATA_W-1:0] word_q, word_d;
  oe_mode_e          mode_q, mode_d;

  always_comb begin
    word_d = word_q;
    mode_d = mode_q;
    if (cfg_we) begin
      word_d = cfg_word;
      mode_d = cfg_sync ? OE_REGD : OE_DIRECT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= {DATA_W{1'b1}};
      mode_q <= OE_DIRECT;
    end else begin
      word_q <= word_d;
      mode_q <= mode_d;
    end
  end

  assign init_word = word_q;
  assign oe_mode   = mode_q;

  // R11: configuration only moves on a strobe
  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(cfg_we)) |-> ($stable(word_q) && $stable(mode_q)));
endmodule

// File: rtl/regrom_outreg.sv
module regrom_outreg
  import regrom_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_n,
  input  logic              oe_n,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] init_word,
  input  oe_mode_e          oe_mode,
  output logic [DATA_W-1:0] data_q,
  output logic              drive_en
);
  logic [DATA_W-1:0] data_d;
  logic              en_q, en_d;

  always_comb begin
    data_d = rd_data;
    en_d   = !oe_n;
  end

  always_ff @(posedge clk or negedge rst_n or negedge init_n) begin
    if (!rst_n)       data_q <= {DATA_W{1'b1}};
    else if (!init_n) data_q <= init_word;
    else              data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n or negedge init_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (!init_n) en_q <= 1'b1;
    else              en_q <= en_d;
  end

  always_comb begin
    if (oe_mode == OE_REGD) drive_en = en_q;
    else                    drive_en = !oe_n;
  end

  // R5: init held low across an edge keeps the init word
  p_init_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_n && !$past(init_n) && $stable(init_word)) |-> (data_q == init_word));

  // R2: with init high, the register shows the array byte of the previous edge
  p_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_n && $past(init_n) && $past(rst_n)) |-> (data_q == $past(rd_data)));

  // R8: registered enable follows the sampled oe_n
  p_regd_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_mode == OE_REGD && init_n && $past(init_n) && $past(rst_n))
      |-> (drive_en == !$past(oe_n)));

  // R9: init low keeps the registered enable on
  p_init_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_n && !$past(init_n)) |-> en_q);
endmodule

// File: rtl/regrom_top.sv
module regrom_top
  import regrom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              init_n,
  input  logic              oe_n,
  input  logic              pgm_we,
  input  logic [ADDR_W-1:0] pgm_addr,
  input  logic [DATA_W-1:0] pgm_data,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_init_word,
  input  logic              cfg_oe_sync,
  output logic [DATA_W-1:0] q,
  output logic              q_valid
);
  logic              srst_n;
  logic [DATA_W-1:0] rd_data;
  logic [DATA_W-1:0] init_word;
  oe_mode_e          oe_mode;
  logic [DATA_W-1:0] data_q;
  logic              drive_en;

  regrom_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  regrom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk     (clk),
    .rst_n   (srst_n),
    .wr_en   (pgm_we),
    .wr_addr (pgm_addr),
    .wr_data (pgm_data),
    .rd_addr (addr),
    .rd_data (rd_data)
  );

  regrom_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk       (clk),
    .rst_n     (srst_n),
    .cfg_we    (cfg_we),
    .cfg_word  (cfg_init_word),
    .cfg_sync  (cfg_oe_sync),
    .init_word (init_word),
    .oe_mode   (oe_mode)
  );

  regrom_outreg #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (srst_n),
    .init_n    (init_n),
    .oe_n      (oe_n),
    .rd_data   (rd_data),
    .init_word (init_word),
    .oe_mode   (oe_mode),
    .data_q    (data_q),
    .drive_en  (drive_en)
  );

  assign q       = drive_en ? data_q : '0;
  assign q_valid = drive_en;

  // R10: undriven outputs read as zero
  p_quiet_r10: assert property (@(posedge clk) disable iff (!srst_n)
    !q_valid |-> (q == '0));
endmodule

// File: tb/regrom_top_tb_top.sv
module regrom_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] addr;
  logic        init_n, oe_n, pgm_we, cfg_we, cfg_oe_sync;
  logic [10:0] pgm_addr;
  logic [7:0]  pgm_data, cfg_init_word;
  logic [7:0]  q;
  logic        q_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [7:0] m_mem [2048];
  logic [7:0] m_q, m_init;
  logic       m_en, m_sync;
  int         wlist [$];

  always #4 clk = ~clk;

  regrom_top dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .init_n(init_n), .oe_n(oe_n),
    .pgm_we(pgm_we), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
    .cfg_we(cfg_we), .cfg_init_word(cfg_init_word), .cfg_oe_sync(cfg_oe_sync),
    .q(q), .q_valid(q_valid)
  );

  task automatic check(input string tag);
    logic       ev;
    logic [7:0] ed;
    ev = m_sync ? m_en : !oe_n;
    ed = ev ? m_q : 8'h00;
    checks++;
    if (q_valid !== ev || q !== ed) begin
      fails++;
      $display("FAIL %s: actual valid=%0b q=%02h expected valid=%0b q=%02h",
               tag, q_valid, q, ev, ed);
    end
  endtask

  task automatic edge_model();
    logic [7:0] rd;
    rd = m_mem[addr];
    if (pgm_we) m_mem[pgm_addr] = pgm_data;
    if (!init_n) begin m_q = m_init; m_en = 1'b1; end
    else begin m_q = rd; m_en = !oe_n; end
    if (cfg_we) begin m_init = cfg_init_word; m_sync = cfg_oe_sync; end
  endtask

  task automatic cyc(input string tag);
    if (!init_n) begin m_q = m_init; m_en = 1'b1; end
    #1 check(tag);
    @(posedge clk);
    edge_model();
    @(negedge clk);
    pgm_we = 1'b0;
    cfg_we = 1'b0;
  endtask

  task automatic set_cfg(input logic [7:0] w, input logic s);
    cfg_we = 1'b1; cfg_init_word = w; cfg_oe_sync = s;
    cyc("R11 cfg write");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2048; i++) m_mem[i] = 8'hFF;
    m_q = 8'hFF; m_init = 8'hFF; m_en = 1'b0; m_sync = 1'b0;
    rst_n = 1'b0; addr = '0; init_n = 1'b1; oe_n = 1'b1;
    pgm_we = 1'b0; pgm_addr = '0; pgm_data = '0;
    cfg_we = 1'b0; cfg_init_word = '0; cfg_oe_sync = 1'b0;
    repeat (3) @(negedge clk);
    #1 check("R12 reset outputs off");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 / R1: erased readout
    cyc("R12 after reset");
    oe_n = 1'b0;
    cyc("R7 direct enable");
    addr = 11'h7FF; cyc("R1 erased top");
    addr = 11'h000; cyc("R1 erased bottom");
    cyc("R1 erased word");

    // R3: program random words, including both ends
    for (int i = 0; i < 40; i++) begin
      int a;
      a = (i == 0) ? 0 : (i == 1) ? 2047 : int'($urandom_range(0, 2047));
      pgm_we = 1'b1; pgm_addr = a[10:0]; pgm_data = 8'($urandom);
      addr = 11'(a ^ 11'h555);
      wlist.push_back(a);
      cyc("R3 program");
    end
    // R2: read back through the register
    foreach (wlist[k]) begin
      addr = wlist[k][10:0];
      cyc("R2 readback");
    end
    for (int i = 0; i < 20; i++) begin
      addr = 11'($urandom_range(0, 2047));
      cyc("R1 R2 mixed read");
    end

    // R4 / R5 / R6: init word loads
    set_cfg(8'h5A, 1'b0);
    addr = wlist[2][10:0]; cyc("R2 before init");
    init_n = 1'b0;
    cyc("R4 init immediate");
    addr = wlist[3][10:0];
    cyc("R5 init held");
    cyc("R5 init held");
    init_n = 1'b1;
    cyc("R5 release");
    cyc("R2 after init");
    set_cfg(8'h00, 1'b0);
    init_n = 1'b0; cyc("R6 clear word");
    init_n = 1'b1; cyc("R6 release");
    set_cfg(8'hFF, 1'b0);
    init_n = 1'b0; cyc("R6 preset word");
    init_n = 1'b1; cyc("R6 release");

    // R10: disabled outputs read zero
    oe_n = 1'b1; cyc("R10 direct off");
    cyc("R10 direct off");

    // R8: registered enable
    set_cfg(8'hC3, 1'b1);
    for (int i = 0; i < 12; i++) begin
      oe_n = (i % 3 == 0);
      addr = wlist[i][10:0];
      cyc("R8 registered enable");
    end
    oe_n = 1'b1; cyc("R8 disable sample");
    cyc("R10 registered off");
    // R9: init forces the registered enable on
    init_n = 1'b0; cyc("R9 init enables");
    cyc("R9 init enables");
    init_n = 1'b1; cyc("R9 release");
    cyc("R8 back to sampled");

    // R11 / R7: back to direct mode
    set_cfg(8'h81, 1'b0);
    oe_n = 1'b0; cyc("R7 direct on");
    oe_n = 1'b1; cyc("R7 direct off");
    oe_n = 1'b0; addr = wlist[5][10:0]; cyc("R7 direct on");
    cyc("R2 final read");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule